// File: doc/BRIEF.md
# Combinational Signed Divider with Quotient and Remainder

This block divides one two's-complement word by another in a single combinational pass and returns both the quotient and the remainder. It first strips both operands to magnitudes. A chain of one step per dividend bit then runs a non-restoring recurrence on those magnitudes, and a single add-back corrects the remainder at the end of the chain. Finally the signs are put back on. The quotient is rounded toward zero, and the remainder carries the sign of the dividend.

A one-bit select chooses which of the two results appears on the shared result output. A zero flag accompanies that output. A zero divisor does not raise an error. It gives a fixed answer: every quotient bit is set, the remainder repeats the dividend, and the zero flag depends only on the select. The block has no clock and no state. It is meant to sit inside an execute stage where the whole path fits in one cycle.

Top module: `signed_divider`

## Requirements
- R1: For a nonzero divisor, `quotient_o` equals the dividend divided by the divisor, rounded toward zero, with its sign the XOR of the two operand sign bits (a zero quotient is simply zero).
- R2: For a nonzero divisor, `remainder_o` is zero or has the sign of the dividend, its magnitude is below the divisor's magnitude, and quotient times divisor plus remainder equals the dividend modulo 2^W.
- R3: The most negative dividend (bit W-1 set, all other bits clear) divided by all ones (-1) gives a quotient equal to the most negative value and a remainder of 0.
- R4: A zero divisor gives `quotient_o` with all W bits set and `remainder_o` equal to `dividend_i`, whatever the dividend.
- R5: `result_o` equals `quotient_o` when `sel_rem_i` is 0 and `remainder_o` when `sel_rem_i` is 1.
- R6: With a nonzero divisor, `zero_o` is 1 exactly when `result_o` is zero.
- R7: With a zero divisor, `zero_o` is 1 when `sel_rem_i` is 0 and 0 when `sel_rem_i` is 1, even if the remainder is zero.
- R8: When the dividend's magnitude is below the divisor's, the quotient is 0 and the remainder equals the dividend.
- R9: The outputs depend only on the present inputs: a new operand pair gives its results within the same cycle, with no history from earlier operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dividend_i | input | W | Dividend, two's complement |
| divisor_i | input | W | Divisor, two's complement |
| sel_rem_i | input | 1 | Result select: 0 selects the quotient, 1 selects the remainder |
| quotient_o | output | W | Signed quotient, rounded toward zero |
| remainder_o | output | W | Signed remainder, with the dividend's sign |
| result_o | output | W | The output chosen by `sel_rem_i` |
| zero_o | output | 1 | Zero flag for `result_o`; fixed by the select when the divisor is zero |

## Verification
The hardest cases to reach are those where the correction and the sign steps interact at the range limits. Examples are the most negative dividend against -1, against +1 and against itself, and a positive dividend with the most negative divisor, whose magnitude has no positive counterpart. Operands drawn at random almost never produce these. A fixed table therefore drives each of them explicitly in both select settings, including zero over zero, where the remainder is zero but the flag must still read 0 in remainder mode. A long pseudo-random run follows, with the divisor often shifted down to a few bits. This produces many nonzero remainders, many late correction add-backs and sign mixes, and each result is compared against a reference built on wide unsigned division.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   typedef enum logic {
      SEL_QUOTIENT  = 1'b0,
      SEL_REMAINDER = 1'b1
   } sdiv_sel_e;

   // Two's-complement negate of an unsigned view.
   function automatic logic [63:0] neg64(input logic [63:0] v);
      return ~v + 64'd1;
   endfunction

endpackage

// File: rtl/sdiv_abs.sv
module sdiv_abs #(
   parameter int W = 32
) (
   input  logic [W-1:0] val_i,
   output logic [W-1:0] mag_o,
   output logic         neg_o
);
   assign neg_o = val_i[W-1];
   assign mag_o = neg_o ? (~val_i + {{(W-1){1'b0}}, 1'b1}) : val_i;
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
   parameter int W              = 32,
   parameter bit SHARED_ADDSUB  = 1'b1
) (
   input  logic [W:0]   part_i,
   input  logic         bit_i,
   input  logic [W-1:0] dmag_i,
   output logic [W:0]   part_o,
   output logic         qbit_o
);
   localparam int PW = W + 1;

   logic [PW-1:0] shifted;
   logic [PW-1:0] dext;
   logic          was_neg;

   assign shifted = {part_i[W-1:0], bit_i};
   assign dext    = {1'b0, dmag_i};
   assign was_neg = part_i[W];

   generate
      if (SHARED_ADDSUB) begin : g_shared
         logic [PW-1:0] operand;
         assign operand = was_neg ? dext : ~dext;
         assign part_o  = shifted + operand + {{(PW-1){1'b0}}, ~was_neg};
      end else begin : g_split
         logic [PW-1:0] sum_add;
         logic [PW-1:0] sum_sub;
         assign sum_add = shifted + dext;
         assign sum_sub = shifted - dext;
         assign part_o  = was_neg ? sum_add : sum_sub;
      end
   endgenerate

   // Digit follows the sign of the fresh partial remainder.
   assign qbit_o = ~part_o[W];
endmodule

// File: rtl/sdiv_array.sv
module sdiv_array #(
   parameter int W             = 32,
   parameter bit SHARED_ADDSUB = 1'b1
) (
   input  logic [W-1:0] nmag_i,
   input  logic [W-1:0] dmag_i,
   output logic [W-1:0] qmag_o,
   output logic [W-1:0] rmag_o
);
   localparam int PW = W + 1;

   logic [PW-1:0] chain [W+1];
   logic [W-1:0]  qbits;
   logic [PW-1:0] last;

   assign chain[0] = '0;

   generate
      for (genvar k = 0; k < W; k++) begin : g_stage
         sdiv_step #(
            .W             (W),
            .SHARED_ADDSUB (SHARED_ADDSUB)
         ) u_step (
            .part_i (chain[k]),
            .bit_i  (nmag_i[W-1-k]),
            .dmag_i (dmag_i),
            .part_o (chain[k+1]),
            .qbit_o (qbits[W-1-k])
         );
      end
   endgenerate

   assign last   = chain[W];
   assign qmag_o = qbits;
   // One add-back brings a negative final remainder into range.
   assign rmag_o = last[W] ? (last[W-1:0] + dmag_i) : last[W-1:0];
endmodule

// File: rtl/sdiv_sign_fix.sv
module sdiv_sign_fix #(
   parameter int W = 32
) (
   input  logic [W-1:0] qmag_i,
   input  logic [W-1:0] rmag_i,
   input  logic         nneg_i,
   input  logic         dneg_i,
   input  logic         dzero_i,
   input  logic [W-1:0] dividend_i,
   output logic [W-1:0] quotient_o,
   output logic [W-1:0] remainder_o
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] q_signed;
   logic [W-1:0] r_signed;

   assign q_signed = (nneg_i ^ dneg_i) ? (~qmag_i + ONE) : qmag_i;
   assign r_signed = nneg_i ? (~rmag_i + ONE) : rmag_i;

   assign quotient_o  = dzero_i ? {W{1'b1}} : q_signed;
   assign remainder_o = dzero_i ? dividend_i : r_signed;
endmodule

// File: rtl/signed_divider.sv
module signed_divider #(
   parameter int W             = 32,
   parameter bit SHARED_ADDSUB = 1'b1
) (
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   input  logic         sel_rem_i,
   output logic [W-1:0] quotient_o,
   output logic [W-1:0] remainder_o,
   output logic [W-1:0] result_o,
   output logic         zero_o
);
   import sdiv_pkg::*;

   generate
      if (W < 2) begin : g_bad_width
         $error("signed_divider: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] nmag;
   logic [W-1:0] dmag;
   logic         nneg;
   logic         dneg;
   logic         dzero;
   logic [W-1:0] qmag;
   logic [W-1:0] rmag;
   sdiv_sel_e    sel;

   assign sel   = sdiv_sel_e'(sel_rem_i);
   assign dzero = (divisor_i == '0);

   sdiv_abs #(.W(W)) u_abs_n (
      .val_i (dividend_i),
      .mag_o (nmag),
      .neg_o (nneg)
   );

   sdiv_abs #(.W(W)) u_abs_d (
      .val_i (divisor_i),
      .mag_o (dmag),
      .neg_o (dneg)
   );

   sdiv_array #(
      .W             (W),
      .SHARED_ADDSUB (SHARED_ADDSUB)
   ) u_array (
      .nmag_i (nmag),
      .dmag_i (dmag),
      .qmag_o (qmag),
      .rmag_o (rmag)
   );

   sdiv_sign_fix #(.W(W)) u_sign (
      .qmag_i      (qmag),
      .rmag_i      (rmag),
      .nneg_i      (nneg),
      .dneg_i      (dneg),
      .dzero_i     (dzero),
      .dividend_i  (dividend_i),
      .quotient_o  (quotient_o),
      .remainder_o (remainder_o)
   );

   always_comb begin
      result_o = (sel == SEL_REMAINDER) ? remainder_o : quotient_o;
      if (dzero) zero_o = (sel == SEL_QUOTIENT);
      else       zero_o = (result_o == '0);
   end
endmodule

// File: rtl/signed_divider_chk.sv
module signed_divider_chk #(
   parameter int W = 32
) (
   input logic [W-1:0] dividend_i,
   input logic [W-1:0] divisor_i,
   input logic         sel_rem_i,
   input logic [W-1:0] quotient_o,
   input logic [W-1:0] remainder_o,
   input logic [W-1:0] result_o,
   input logic         zero_o
);
   logic [W-1:0] r_abs;
   logic [W-1:0] d_abs;
   logic [W-1:0] recon;

   always_comb begin
      r_abs = remainder_o[W-1] ? (~remainder_o + 1'b1) : remainder_o;
      d_abs = divisor_i[W-1]   ? (~divisor_i + 1'b1)   : divisor_i;
      recon = quotient_o * divisor_i + remainder_o;

      // R4
      dz_result_chk: assert (divisor_i != '0 ||
                             (quotient_o == {W{1'b1}} && remainder_o == dividend_i));
      // R2
      rem_bound_chk: assert (divisor_i == '0 || r_abs < d_abs);
      // R2
      rem_sign_chk: assert (divisor_i == '0 || remainder_o == '0 ||
                            remainder_o[W-1] == dividend_i[W-1]);
      // R2
      identity_chk: assert (divisor_i == '0 || recon == dividend_i);
      // R5
      select_chk: assert (result_o == (sel_rem_i ? remainder_o : quotient_o));
      // R6
      zero_flag_chk: assert (divisor_i == '0 || zero_o == (result_o == '0));
      // R7
      dz_flag_chk: assert (divisor_i != '0 || zero_o == ~sel_rem_i);
   end
endmodule

bind signed_divider signed_divider_chk #(.W(W)) u_chk (
   .dividend_i  (dividend_i),
   .divisor_i   (divisor_i),
   .sel_rem_i   (sel_rem_i),
   .quotient_o  (quotient_o),
   .remainder_o (remainder_o),
   .result_o    (result_o),
   .zero_o      (zero_o)
);

// File: tb/test_signed_divider.sv
module test_signed_divider;

   localparam int  W       = 32;
   localparam int  NRAND   = 3000;
   localparam int  NVEC    = 14;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] dividend;
   logic [W-1:0] divisor;
   logic         sel_rem;
   logic [W-1:0] quotient;
   logic [W-1:0] remainder;
   logic [W-1:0] result;
   logic         zero;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   signed_divider #(.W(W)) i_signed_divider (
      .dividend_i  (dividend),
      .divisor_i   (divisor),
      .sel_rem_i   (sel_rem),
      .quotient_o  (quotient),
      .remainder_o (remainder),
      .result_o    (result),
      .zero_o      (zero)
   );

   // {dividend, divisor, quotient, remainder}
   localparam logic [127:0] TBL [NVEC] = '{
      {32'h00000064, 32'h00000007, 32'h0000000E, 32'h00000002},
      {32'hFFFFFF9C, 32'h00000007, 32'hFFFFFFF2, 32'hFFFFFFFE},
      {32'h00000064, 32'hFFFFFFF9, 32'hFFFFFFF2, 32'h00000002},
      {32'hFFFFFF9C, 32'hFFFFFFF9, 32'h0000000E, 32'hFFFFFFFE},
      {32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'h00000000},
      {32'h80000000, 32'h00000001, 32'h80000000, 32'h00000000},
      {32'h00000007, 32'h00000064, 32'h00000000, 32'h00000007},
      {32'h00000005, 32'h00000000, 32'hFFFFFFFF, 32'h00000005},
      {32'h7FFFFFFF, 32'h80000000, 32'h00000000, 32'h7FFFFFFF},
      {32'h80000000, 32'h80000000, 32'h00000001, 32'h00000000},
      {32'hFFFFFFF9, 32'h00000064, 32'h00000000, 32'hFFFFFFF9},
      {32'h7FFFFFFF, 32'h00000002, 32'h3FFFFFFF, 32'h00000001},
      {32'h0000000C, 32'h00000004, 32'h00000003, 32'h00000000},
      {32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00000000}
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: n=%h d=%h sel=%0d actual=%h expected=%h",
                  req, dividend, divisor, sel_rem, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] n, input logic [W-1:0] d, input logic s);
      @(negedge clk);
      dividend = n;
      divisor  = d;
      sel_rem  = s;
      @(posedge clk);
      #1;
   endtask

   function automatic void ref_div(input logic [W-1:0] n, input logic [W-1:0] d,
                                   output logic [W-1:0] q, output logic [W-1:0] r);
      logic [W:0] sn, sd, ma, mb, qm, rm;
      if (d == '0) begin
         q = '1;
         r = n;
      end else begin
         sn = {n[W-1], n};
         sd = {d[W-1], d};
         ma = n[W-1] ? (~sn + 1'b1) : sn;
         mb = d[W-1] ? (~sd + 1'b1) : sd;
         qm = ma / mb;
         rm = ma % mb;
         q  = (n[W-1] ^ d[W-1]) ? (~qm[W-1:0] + 1'b1) : qm[W-1:0];
         r  = n[W-1] ? (~rm[W-1:0] + 1'b1) : rm[W-1:0];
      end
   endfunction

   // Checks of all four outputs against a known quotient/remainder pair.
   task automatic check_all(input string qreq, input string rreq,
                            input logic [W-1:0] eq, input logic [W-1:0] er);
      logic [W-1:0] eres;
      logic         ez;
      eres = sel_rem ? er : eq;
      ez   = (divisor == '0) ? ~sel_rem : (eres == '0);
      chk(qreq, quotient, eq);
      chk(rreq, remainder, er);
      chk("R5 result select", result, eres);
      chk((divisor == '0) ? "R7 zero flag on zero divisor" : "R6 zero flag",
          {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, ez});
   endtask

   initial begin
      dividend = '0;
      divisor  = '0;
      sel_rem  = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // Reset-time state: 0 / 0 in quotient mode (R4, R7)
      chk("R4 reset quotient", quotient, '1);
      chk("R4 reset remainder", remainder, '0);
      chk("R7 reset zero flag", {{(W-1){1'b0}}, zero}, 32'd1);
      @(negedge clk);
      rst = 1'b0;

      // Table of fixed vectors, both selects (R1 R2 R3 R4 R5 R6 R7 R8)
      for (int v = 0; v < NVEC; v++) begin
         for (int s = 0; s < 2; s++) begin
            apply(TBL[v][127:96], TBL[v][95:64], s[0]);
            check_all("R1 table quotient", "R2 table remainder",
                      TBL[v][63:32], TBL[v][31:0]);
         end
      end

      // R3: most negative over -1 wraps
      apply(32'h80000000, 32'hFFFFFFFF, 1'b0);
      chk("R3 wrap quotient", quotient, 32'h80000000);
      chk("R3 wrap remainder", remainder, 32'h00000000);

      // R4: zero divisor with negative dividend
      apply(32'h80000001, 32'h00000000, 1'b1);
      chk("R4 zero divisor quotient", quotient, 32'hFFFFFFFF);
      chk("R4 zero divisor remainder", remainder, 32'h80000001);
      chk("R7 zero divisor remainder mode flag", {{(W-1){1'b0}}, zero}, 32'd0);

      // R8: small dividend against large divisor
      apply(32'hFFFFFFFE, 32'h7FFFFFFF, 1'b1);
      chk("R8 small dividend quotient", quotient, 32'h00000000);
      chk("R8 small dividend remainder", remainder, 32'hFFFFFFFE);

      // R9: no history - same operands after a very different pair
      apply(32'h00000064, 32'h00000007, 1'b0);
      apply(32'h80000000, 32'h00000000, 1'b1);
      apply(32'h00000064, 32'h00000007, 1'b1);
      chk("R9 no history remainder", remainder, 32'h00000002);
      chk("R9 no history result", result, 32'h00000002);

      // Pseudo-random sweep against the reference (R1 R2 R5 R6 R7)
      begin
         logic [W-1:0] x;
         logic [W-1:0] nn, dd, eq, er;
         x = 32'h1234ABCD;
         for (int i = 0; i < NRAND; i++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            nn = x;
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            dd = (i % 3 == 0) ? x : (x >> x[4:0]);
            if (i % 97 == 0) dd = '0;
            apply(nn, dd, x[7]);
            ref_div(nn, dd, eq, er);
            check_all("R1 random quotient", "R2 random remainder", eq, er);
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule